// File: doc/BRIEF.md
# Counted Handshake Sequence Monitor

This block is a synthesizable runtime observer that sits beside a design and watches five single-bit handshake signals: a trigger, a grab event, an abort, a give event and a done marker. A trigger opens an attempt. From the next cycle, the attempt counts grab events. The grabs may be spread out with idle cycles between them, and the abort signal must stay low the whole time. When the configured number of grabs has been seen, the attempt moves into an obligation phase. In that phase, done must not rise until the same number of give events have occurred.

A violation produces a registered one-cycle error pulse and sets a sticky failure flag that only reset clears. An abort during grab counting drops the attempt quietly, because the triggering condition did not hold. Several attempts can be in flight at once, each in its own slot. A trigger that finds every slot busy sets a sticky overflow flag instead of being tracked.

Top module: `seq_obligation_monitor`

## Requirements
- R1: After a synchronous reset, `err_o`, `fail_o` and `ovf_o` are 0 and every slot is idle.
- R2: A cycle with `trig_i` high opens an attempt. Grab counting starts on the next cycle, so a grab on the trigger cycle is not counted.
- R3: Grabs need not be consecutive. The attempt enters its obligation phase on the cycle after exactly COUNT (default 8) grabs have been counted.
- R4: If `abort_i` is high on any cycle while grabs are being counted, the attempt is dropped and no error is raised.
- R5: In the obligation phase, `done_i` high while fewer than COUNT gives have been counted (including a give on that same cycle) is a violation. `err_o` is high on the cycle after it.
- R6: A give on the same cycle as `done_i` counts first, so `done_i` on the cycle of the COUNT-th give is legal. After COUNT gives the attempt retires, and a later `done_i` raises nothing.
- R7: `err_o` is high for one cycle per violating cycle. `fail_o` rises with the first error and stays high until reset.
- R8: Up to SLOTS (default 4) attempts are tracked independently. A trigger while all slots are busy sets `ovf_o`, which stays high until reset.
- R9: `done_i` has no effect on an attempt that is still counting grabs.
- R10: `abort_i` has no effect on an attempt that is in its obligation phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Opens a new attempt |
| grab_i | input | 1 | Event counted in the first phase |
| abort_i | input | 1 | Cancels attempts still in the first phase |
| give_i | input | 1 | Event counted in the obligation phase |
| done_i | input | 1 | Marker that is forbidden until the obligation is met |
| err_o | output | 1 | One-cycle pulse, registered, on a violation |
| fail_o | output | 1 | Sticky violation flag |
| ovf_o | output | 1 | Sticky flag: a trigger arrived with no free slot |

## Verification
The embedded assertions assume that all five observed inputs carry known values on every clock edge and that reset is applied before the first trigger. They also assume that each input is a plain level sampled once per cycle, with no meaning attached to pulses narrower than a cycle. The stimulus drives every input at the falling edge, so values are stable at each rising edge. It begins every sequence with reset. Triggers stay rare in the random phases, so most attempts find a free slot, while directed runs push the pool into overflow on purpose.

// File: rtl/hsmon_pkg.sv
package hsmon_pkg;
    typedef enum logic [1:0] {
        SL_IDLE    = 2'd0,
        SL_COLLECT = 2'd1,
        SL_OBLIG   = 2'd2
    } slot_st_e;
endpackage

// File: rtl/hsmon_alloc.sv
module hsmon_alloc #(
    parameter int SLOTS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [SLOTS-1:0] free,
    output logic [SLOTS-1:0] grant,
    output logic             full
);
    // lowest free slot wins
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (req && free[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
        full = (free == '0);
    end

    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    p_grant_free_r8: assert property (@(posedge clk) disable iff (rst)
        (grant & ~free) == '0);
    p_grant_when_room_r8: assert property (@(posedge clk) disable iff (rst)
        (req && !full) |-> (grant != '0));
endmodule

// File: rtl/hsmon_slot.sv
module hsmon_slot
    import hsmon_pkg::*;
#(
    parameter int COUNT = 8,
    localparam int CW = $clog2(COUNT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic grab,
    input  logic abort,
    input  logic give,
    input  logic done,
    output logic busy,
    output logic viol
);
    typedef struct packed {
        slot_st_e        st;
        logic [CW-1:0]   cnt;
    } slot_t;

    slot_t         slot_d, slot_q;
    logic [CW-1:0] tally;

    always_comb begin
        slot_d = slot_q;
        viol   = 1'b0;
        tally  = slot_q.cnt + {{(CW-1){1'b0}}, give};
        case (slot_q.st)
            SL_IDLE: begin
                if (launch) begin
                    slot_d.st  = SL_COLLECT;
                    slot_d.cnt = '0;
                end
            end
            SL_COLLECT: begin
                if (abort) begin
                    slot_d.st  = SL_IDLE;
                    slot_d.cnt = '0;
                end else if (grab) begin
                    if (slot_q.cnt == CW'(COUNT - 1)) begin
                        slot_d.st  = SL_OBLIG;
                        slot_d.cnt = '0;
                    end else begin
                        slot_d.cnt = slot_q.cnt + 1'b1;
                    end
                end
            end
            SL_OBLIG: begin
                if (tally == CW'(COUNT)) begin
                    slot_d.st  = SL_IDLE;
                    slot_d.cnt = '0;
                end else if (done) begin
                    viol       = 1'b1;
                    slot_d.st  = SL_IDLE;
                    slot_d.cnt = '0;
                end else begin
                    slot_d.cnt = tally;
                end
            end
            default: begin
                slot_d.st  = SL_IDLE;
                slot_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q.st  <= SL_IDLE;
            slot_q.cnt <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign busy = (slot_q.st != SL_IDLE);

    p_launch_r2: assert property (@(posedge clk) disable iff (rst)
        (slot_q.st == SL_IDLE && launch) |=> (slot_q.st == SL_COLLECT && slot_q.cnt == '0));
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (slot_q.st != SL_IDLE) |-> (slot_q.cnt < CW'(COUNT)));
    p_abort_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (slot_q.st == SL_COLLECT && abort) |=> (slot_q.st == SL_IDLE));
    p_viol_only_oblig_r5: assert property (@(posedge clk) disable iff (rst)
        viol |-> (slot_q.st == SL_OBLIG && done));
    p_done_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (slot_q.st == SL_COLLECT) |-> !viol);
    p_oblig_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (slot_q.st == SL_OBLIG && !done && !give) |=> (slot_q.st == SL_OBLIG && $stable(slot_q.cnt)));
endmodule

// File: rtl/seq_obligation_monitor.sv
module seq_obligation_monitor #(
    parameter int COUNT = 8,
    parameter int SLOTS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    input  logic grab_i,
    input  logic abort_i,
    input  logic give_i,
    input  logic done_i,
    output logic err_o,
    output logic fail_o,
    output logic ovf_o
);
    typedef struct packed {
        logic err;
        logic fail;
        logic ovf;
    } flags_t;

    flags_t           flags_d, flags_q;
    logic [SLOTS-1:0] busy, viol, grant;
    logic             full;

    hsmon_alloc #(.SLOTS(SLOTS)) u_alloc (
        .clk   (clk),
        .rst   (rst),
        .req   (trig_i),
        .free  (~busy),
        .grant (grant),
        .full  (full)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        hsmon_slot #(.COUNT(COUNT)) u_slot (
            .clk    (clk),
            .rst    (rst),
            .launch (grant[g]),
            .grab   (grab_i),
            .abort  (abort_i),
            .give   (give_i),
            .done   (done_i),
            .busy   (busy[g]),
            .viol   (viol[g])
        );
    end

    always_comb begin
        flags_d      = flags_q;
        flags_d.err  = |viol;
        flags_d.fail = flags_q.fail | (|viol);
        flags_d.ovf  = flags_q.ovf | (trig_i & full);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign err_o  = flags_q.err;
    assign fail_o = flags_q.fail;
    assign ovf_o  = flags_q.ovf;

    p_fail_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        fail_o |=> fail_o);
    p_err_sets_fail_r7: assert property (@(posedge clk) disable iff (rst)
        err_o |-> fail_o);
    p_err_registered_r5: assert property (@(posedge clk) disable iff (rst)
        (viol != '0) |=> err_o);
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (trig_i && busy != '1) |=> ($stable(ovf_o)));
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);
endmodule

// File: tb/seq_obligation_monitor_test.sv
`timescale 1ns/1ps
module seq_obligation_monitor_test;
    localparam int N = 8;
    localparam int S = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 0, grab = 0, abrt = 0, give = 0, done = 0;
    logic err, fail, ovf;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int ms [S];
    int mc [S];
    bit e_err, e_fail, e_ovf;

    always #2.5 clk = ~clk;

    seq_obligation_monitor #(.COUNT(N), .SLOTS(S)) uut (
        .clk(clk), .rst(rst), .trig_i(trig), .grab_i(grab), .abort_i(abrt),
        .give_i(give), .done_i(done), .err_o(err), .fail_o(fail), .ovf_o(ovf)
    );

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // reference: 0 idle, 1 counting grabs, 2 counting gives
    task automatic model_step(bit s, bit g, bit k, bit p, bit e);
        int f = -1;
        bit v = 0;
        for (int i = 0; i < S; i++) if (f < 0 && ms[i] == 0) f = i;
        for (int i = 0; i < S; i++) begin
            if (ms[i] == 1) begin
                if (k) ms[i] = 0;
                else if (g) begin
                    mc[i]++;
                    if (mc[i] == N) begin ms[i] = 2; mc[i] = 0; end
                end
            end else if (ms[i] == 2) begin
                if (p) mc[i]++;
                if (mc[i] == N) begin ms[i] = 0; mc[i] = 0; end
                else if (e) begin v = 1; ms[i] = 0; mc[i] = 0; end
            end
        end
        if (s) begin
            if (f >= 0) begin ms[f] = 1; mc[f] = 0; end
            else e_ovf = 1;
        end
        e_err  = v;
        e_fail = e_fail | v;
    endtask

    task automatic do_reset();
        rst = 1; trig = 0; grab = 0; abrt = 0; give = 0; done = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < S; i++) begin ms[i] = 0; mc[i] = 0; end
        e_err = 0; e_fail = 0; e_ovf = 0;
        check("R1 err", err, 1'b0);
        check("R1 fail", fail, 1'b0);
        check("R1 ovf", ovf, 1'b0);
    endtask

    task automatic cyc(bit s, bit g, bit k, bit p, bit e);
        trig = s; grab = g; abrt = k; give = p; done = e;
        model_step(s, g, k, p, e);
        @(posedge clk);
        #1;
        check("R5 err model", err, e_err);
        check("R7 fail model", fail, e_fail);
        check("R8 ovf model", ovf, e_ovf);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R2 + R9: grab on trigger cycle ignored, done early in counting phase ignored
        cyc(1, 1, 0, 0, 0);
        for (int i = 0; i < 7; i++) cyc(0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 1);
        check("R9 done in counting", err, 1'b0);
        check("R2 still counting", fail, 1'b0);
        cyc(0, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 1);
        check("R5 early done", err, 1'b1);
        cyc(0, 0, 0, 0, 0);
        check("R7 err pulse", err, 1'b0);
        check("R7 fail sticky", fail, 1'b1);
        for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 0);
        check("R7 fail holds", fail, 1'b1);
        do_reset();

        // R3 + R6 + R10: spaced grabs, abort in obligation, done on last give
        cyc(1, 0, 0, 0, 0);
        for (int i = 0; i < N; i++) begin cyc(0, 1, 0, 0, 0); cyc(0, 0, 0, 0, 0); end
        for (int i = 0; i < N - 1; i++) begin cyc(0, 0, 1, 1, 0); cyc(0, 0, 0, 0, 0); end
        cyc(0, 0, 0, 1, 1);
        check("R6 done on final give", err, 1'b0);
        cyc(0, 0, 0, 0, 1);
        check("R6 retired", err, 1'b0);
        check("R10 abort ignored", fail, 1'b0);
        do_reset();

        // R3: done one give short is a violation
        cyc(1, 0, 0, 0, 0);
        for (int i = 0; i < N; i++) cyc(0, 1, 0, 0, 0);
        for (int i = 0; i < N - 2; i++) cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 1);
        check("R3 one give short", err, 1'b1);
        do_reset();

        // R4: abort drops attempt
        cyc(1, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0);
        cyc(0, 0, 1, 0, 0);
        for (int i = 0; i < N; i++) cyc(0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 1);
        check("R4 aborted no err", err, 1'b0);
        check("R4 aborted no fail", fail, 1'b0);
        do_reset();

        // R8: pool exhaustion
        for (int i = 0; i < S; i++) cyc(1, 0, 0, 0, 0);
        check("R8 no ovf at capacity", ovf, 1'b0);
        cyc(1, 0, 0, 0, 0);
        check("R8 ovf set", ovf, 1'b1);
        for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 0);
        check("R8 ovf sticky", ovf, 1'b1);
        do_reset();

        // random phases
        void'($urandom(32'h1d5e));
        for (int ph = 0; ph < 3; ph++) begin
            int pt, pg, pk, pp, pe;
            pt = (ph == 0) ? 20 : (ph == 1) ? 8 : 40;
            pg = (ph == 2) ? 4 : 2;
            pk = (ph == 1) ? 80 : 30;
            pp = (ph == 0) ? 2 : 3;
            pe = (ph == 2) ? 30 : 10;
            do_reset();
            for (int c = 0; c < 4000; c++) begin
                cyc(($urandom % pt) == 0, ($urandom % pg) == 0, ($urandom % pk) == 0,
                    ($urandom % pp) == 0, ($urandom % pe) == 0);
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule